// File: doc/BRIEF.md
# ISA Bus Master Cycle Engine

This block converts single transfer requests from a local request port into 16-bit ISA bus cycles. The requester presents a request with an I/O-or-memory select, a read-or-write select, a 24-bit address, write data and two byte enables. It holds the request until the block answers with a one-cycle done pulse. On a read, the read data comes with that pulse.

On the bus side the block generates the bus clock by dividing the system clock. It places the latched and unlatched address lines on the bus and pulses the address latch enable for one bus clock. It then asserts exactly one of four active-low command strobes for a fixed number of bus clocks. The data lines are brought out as separate output, output-enable and input pins, so that the pad ring can form the tri-state bus. The output enable is raised only for writes.

Top module: `isa_cycle_engine`

## Requirements
- R1: The bus clock output has a period of exactly 2*BCLK_HALF system clocks.
- R2: While the address latch enable is high, the lower address output shows request address bits 19..1 together with the computed bit 0 (see R9), and the upper address output shows request bits 23..17. The enable stays high for exactly one bus clock (2*BCLK_HALF system clocks).
- R3: Both address outputs stay the same from the first to the last cycle in which the address latch enable is high.
- R4: Each request asserts exactly one strobe. I/O read is used when io=1 and wr=0, I/O write when io=1 and wr=1, memory read when io=0 and wr=0, and memory write when io=0 and wr=1.
- R5: The strobe falls in the same cycle that the address latch enable falls, never overlaps it, and stays low for exactly CMD_BCLKS bus clocks (CMD_BCLKS*2*BCLK_HALF system clocks).
- R6: Done is high for exactly one system clock per request, in the first cycle after the strobe is released.
- R7: On a read, the read data output given with done equals the value on the data input during the last cycle of the command phase.
- R8: The data output enable is high only during a write command phase and the one cycle after it (the done cycle). During that time the data output carries the request's write data. At all other times the enable is low.
- R9: The byte enables (bit 1 = upper byte, bit 0 = lower byte) set the bus signals as follows. The byte-high enable is low exactly when bit 1 is set. Address bit 0 is 1 only for the pattern 2'b10. Request address bit 0 is ignored.
- R10: A request is taken only while the block is idle. Changes to the request inputs after it is taken do not affect the cycle in progress, and each request produces exactly one address-latch pulse.
- R11: During and right after reset, all strobes and the byte-high enable are high, the address latch enable, done and the data output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, held until done |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 24 | Byte address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 1 upper byte |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with done |
| isa_clk_o | output | 1 | Generated bus clock |
| isa_ale_o | output | 1 | Address latch enable |
| isa_addr_o | output | 20 | Latched system address |
| isa_hiaddr_o | output | 7 | Unlatched address bits 23..17 |
| isa_hbe_n_o | output | 1 | Byte-high enable, active low |
| isa_iord_n_o | output | 1 | I/O read strobe, active low |
| isa_iowr_n_o | output | 1 | I/O write strobe, active low |
| isa_mrd_n_o | output | 1 | Memory read strobe, active low |
| isa_mwr_n_o | output | 1 | Memory write strobe, active low |
| isa_dat_o | output | 16 | Data driven onto the bus |
| isa_dat_oe_o | output | 1 | Data output enable |
| isa_dat_i | input | 16 | Data sampled from the bus |

## Verification
Directed cycles cover all four command kinds. They also cover each byte-enable pattern, so a swapped strobe decode or a wrong bit-0/byte-high mapping shows up as a wrong strobe or address. All-ones and all-zero addresses separate the latched bits from the unlatched bits. Random cycles vary the address, data and kind. In every cycle the request inputs are changed in the middle of the cycle, which shows whether the block latched the request or passes the inputs straight through. Bus-side timing (latch width, strobe length, done placement and drive window) is measured in system clocks, which catches off-by-one errors in the phase counting.

// File: rtl/isa_cyc_pkg.sv
package isa_cyc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ALE,
    ST_CMD,
    ST_FIN
  } cyc_state_t;
endpackage

// File: rtl/isa_bclk_gen.sv
module isa_bclk_gen #(
  parameter int BCLK_HALF = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic rise_tick
);
  localparam int CW = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          bclk_d;
  logic          wrap;

  always_comb begin
    wrap      = (cnt_q == CW'(BCLK_HALF - 1));
    cnt_d     = wrap ? '0 : cnt_q + 1'b1;
    bclk_d    = wrap ? ~bclk : bclk;
    rise_tick = wrap && !bclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bclk  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bclk  <= bclk_d;
    end
  end

  AST_TICK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> bclk) else $error("tick not followed by bus clock high"); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BCLK_HALF - 1)) else $error("divider counter out of range"); // R1
endmodule

// File: rtl/isa_lane_map.sv
module isa_lane_map (
  input  logic [1:0] be,
  output logic       a0,
  output logic       hbe_n
);
  always_comb begin
    a0    = be[1] & ~be[0];
    hbe_n = ~be[1];
  end
endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
  import isa_cyc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int SA_W      = 20,
  parameter int LA_LSB    = 17,
  parameter int CMD_BCLKS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    req,
  input  logic                    is_io,
  input  logic                    is_wr,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [1:0]              be,
  input  logic [DATA_W-1:0]       d_in,
  output logic                    ale,
  output logic                    iord_n,
  output logic                    iowr_n,
  output logic                    mrd_n,
  output logic                    mwr_n,
  output logic [SA_W-1:0]         sa,
  output logic [ADDR_W-LA_LSB-1:0] la,
  output logic                    hbe_n,
  output logic [DATA_W-1:0]       d_out,
  output logic                    d_oe,
  output logic                    done,
  output logic [DATA_W-1:0]       rdata
);
  localparam int CCW = (CMD_BCLKS > 1) ? $clog2(CMD_BCLKS) : 1;

  cyc_state_t        state_q, state_d;
  logic [CCW-1:0]    cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              io_q, wr_q, hbe_q;
  logic              accept, last_cmd, a0_map, hbe_map;

  isa_lane_map u_lane (.be(be), .a0(a0_map), .hbe_n(hbe_map));

  always_comb begin
    accept   = (state_q == ST_IDLE) && req;
    last_cmd = (state_q == ST_CMD) && tick && (cnt_q == '0);
    state_d  = state_q;
    cnt_d    = cnt_q;
    unique case (state_q)
      ST_IDLE: if (req) state_d = ST_ADDR;
      ST_ADDR: if (tick) state_d = ST_ALE;
      ST_ALE:  if (tick) begin
                 state_d = ST_CMD;
                 cnt_d   = CCW'(CMD_BCLKS - 1);
               end
      ST_CMD:  if (tick) begin
                 if (cnt_q == '0) state_d = ST_FIN;
                 else             cnt_d   = cnt_q - 1'b1;
               end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      hbe_q   <= 1'b1;
    end else if (accept) begin
      addr_q  <= {addr[ADDR_W-1:1], a0_map};
      wdata_q <= wdata;
      io_q    <= is_io;
      wr_q    <= is_wr;
      hbe_q   <= hbe_map;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (last_cmd) rdata_q <= d_in;
  end

  always_comb begin
    ale    = (state_q == ST_ALE);
    iord_n = !((state_q == ST_CMD) &&  io_q && !wr_q);
    iowr_n = !((state_q == ST_CMD) &&  io_q &&  wr_q);
    mrd_n  = !((state_q == ST_CMD) && !io_q && !wr_q);
    mwr_n  = !((state_q == ST_CMD) && !io_q &&  wr_q);
    sa     = addr_q[SA_W-1:0];
    la     = addr_q[ADDR_W-1:LA_LSB];
    hbe_n  = (state_q == ST_IDLE) ? 1'b1 : hbe_q;
    d_oe   = ((state_q == ST_CMD) || (state_q == ST_FIN)) && wr_q;
    d_out  = wdata_q;
    done   = (state_q == ST_FIN);
    rdata  = rdata_q;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({iord_n, iowr_n, mrd_n, mwr_n}) >= 3) else $error("two strobes low"); // R4
  AST_ALE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (iord_n && iowr_n && mrd_n && mwr_n)) else $error("strobe during latch enable"); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> ($stable(sa) && $stable(la))) else $error("address moved during latch"); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R6
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> ($stable(io_q) && $stable(wr_q) && $stable(wdata_q)))
    else $error("request fields changed mid cycle"); // R10
endmodule

// File: rtl/isa_cycle_engine.sv
module isa_cycle_engine #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int SA_W      = 20,
  parameter int LA_LSB    = 17,
  parameter int BCLK_HALF = 16,
  parameter int CMD_BCLKS = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_i,
  input  logic                     req_io_i,
  input  logic                     req_wr_i,
  input  logic [ADDR_W-1:0]        req_addr_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  input  logic [1:0]               req_be_i,
  output logic                     done_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     isa_clk_o,
  output logic                     isa_ale_o,
  output logic [SA_W-1:0]          isa_addr_o,
  output logic [ADDR_W-LA_LSB-1:0] isa_hiaddr_o,
  output logic                     isa_hbe_n_o,
  output logic                     isa_iord_n_o,
  output logic                     isa_iowr_n_o,
  output logic                     isa_mrd_n_o,
  output logic                     isa_mwr_n_o,
  output logic [DATA_W-1:0]        isa_dat_o,
  output logic                     isa_dat_oe_o,
  input  logic [DATA_W-1:0]        isa_dat_i
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  isa_bclk_gen #(.BCLK_HALF(BCLK_HALF)) u_bclk (
    .clk(clk), .rst_n(rst_int_n), .bclk(isa_clk_o), .rise_tick(tick)
  );

  isa_cycle_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SA_W(SA_W),
    .LA_LSB(LA_LSB), .CMD_BCLKS(CMD_BCLKS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .tick(tick),
    .req(req_i), .is_io(req_io_i), .is_wr(req_wr_i),
    .addr(req_addr_i), .wdata(req_wdata_i), .be(req_be_i),
    .d_in(isa_dat_i),
    .ale(isa_ale_o),
    .iord_n(isa_iord_n_o), .iowr_n(isa_iowr_n_o),
    .mrd_n(isa_mrd_n_o), .mwr_n(isa_mwr_n_o),
    .sa(isa_addr_o), .la(isa_hiaddr_o), .hbe_n(isa_hbe_n_o),
    .d_out(isa_dat_o), .d_oe(isa_dat_oe_o),
    .done(done_o), .rdata(rdata_o)
  );

  AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    isa_dat_oe_o |-> (!isa_iowr_n_o || !isa_mwr_n_o || done_o))
    else $error("data driven outside write window"); // R8
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!isa_iord_n_o || !isa_mrd_n_o) |-> !isa_dat_oe_o)
    else $error("data driven during read"); // R8
endmodule

// File: tb/tb_isa_cycle_engine.sv
`timescale 1ns/1ps
module tb_isa_cycle_engine;
  localparam int H   = 16;
  localparam int CMD = 3;

  logic clk, rst_n;
  logic req, rio, rwr;
  logic [23:0] raddr;
  logic [15:0] rwdata;
  logic [1:0]  rbe;
  logic        done;
  logic [15:0] rdata;
  logic        bclk, ale, hbe_n, iord_n, iowr_n, mrd_n, mwr_n, oe;
  logic [19:0] sa;
  logic [6:0]  la;
  logic [15:0] dat_o, dat_i;

  logic [15:0] cur_wdata, cur_rd;
  int checks, errs;

  isa_cycle_engine #(.BCLK_HALF(H), .CMD_BCLKS(CMD)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_io_i(rio), .req_wr_i(rwr),
    .req_addr_i(raddr), .req_wdata_i(rwdata), .req_be_i(rbe),
    .done_o(done), .rdata_o(rdata), .isa_clk_o(bclk), .isa_ale_o(ale),
    .isa_addr_o(sa), .isa_hiaddr_o(la), .isa_hbe_n_o(hbe_n),
    .isa_iord_n_o(iord_n), .isa_iowr_n_o(iowr_n), .isa_mrd_n_o(mrd_n),
    .isa_mwr_n_o(mwr_n), .isa_dat_o(dat_o), .isa_dat_oe_o(oe), .isa_dat_i(dat_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // peripheral model: drives read data while a read strobe is low
  assign dat_i = (!iord_n || !mrd_n) ? cur_rd : 16'h0000;

  // bus monitor: records measurements, main process checks them
  logic [3:0]  lv, prev_low;
  logic        prev_ale, prev_bclk, fall_with_strobe;
  int          ale_len, low_len, bper, bcnt;
  logic [19:0] sa_rise, sa_fall;
  logic [6:0]  la_rise, la_fall;
  logic        hbe_fall;
  logic [3:0]  low_mask;
  logic [15:0] rdata_rec;
  int multi_cnt, overlap_cnt, done_cnt, done_ok_cnt, oe_bad, ale_rises;
  logic mon_en;

  initial begin
    prev_low = 0; prev_ale = 0; prev_bclk = 0; fall_with_strobe = 0;
    ale_len = 0; low_len = 0; bper = 0; bcnt = 0;
    sa_rise = 0; sa_fall = 0; la_rise = 0; la_fall = 0; hbe_fall = 1;
    low_mask = 0; rdata_rec = 0;
    multi_cnt = 0; overlap_cnt = 0; done_cnt = 0; done_ok_cnt = 0;
    oe_bad = 0; ale_rises = 0;
  end

  always @(negedge clk) begin
    if (mon_en) begin
      lv = ~{iord_n, iowr_n, mrd_n, mwr_n};
      if (bclk && !prev_bclk) begin bper = bcnt; bcnt = 1; end
      else bcnt = bcnt + 1;
      if (ale && !prev_ale) begin
        ale_len = 1; sa_rise = sa; la_rise = la; ale_rises = ale_rises + 1;
      end else if (ale) ale_len = ale_len + 1;
      if (!ale && prev_ale) begin
        sa_fall = sa; la_fall = la; hbe_fall = hbe_n; fall_with_strobe = (lv != 0);
      end
      if (lv != 0 && prev_low == 0) begin low_len = 1; low_mask = lv; end
      else if (lv != 0) begin low_len = low_len + 1; low_mask = low_mask | lv; end
      if ($countones(lv) > 1) multi_cnt = multi_cnt + 1;
      if (ale && lv != 0) overlap_cnt = overlap_cnt + 1;
      if (oe != (lv[2] || lv[0] || (done && (prev_low[2] || prev_low[0]))))
        oe_bad = oe_bad + 1;
      else if (oe && dat_o != cur_wdata) oe_bad = oe_bad + 1;
      if (done) begin
        done_cnt = done_cnt + 1;
        if (prev_low != 0 && lv == 0) done_ok_cnt = done_ok_cnt + 1;
        rdata_rec = rdata;
      end
      prev_low = lv; prev_ale = ale; prev_bclk = bclk;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_mask(input logic io, input logic wr);
    // bit order {iord, iowr, mrd, mwr}
    return io ? (wr ? 4'b0100 : 4'b1000) : (wr ? 4'b0001 : 4'b0010);
  endfunction
  function automatic logic [19:0] exp_sa(input logic [23:0] a, input logic [1:0] be);
    return {a[19:1], (be == 2'b10)};
  endfunction
  function automatic logic exp_hbe(input logic [1:0] be);
    return !be[1];
  endfunction

  task automatic do_op(input logic io, input logic wr, input logic [23:0] a,
                       input logic [15:0] wd, input logic [1:0] be);
    int m0, ov0, d0, dk0, ob0, ar0, n;
    bit seen;
    m0 = multi_cnt; ov0 = overlap_cnt; d0 = done_cnt; dk0 = done_ok_cnt;
    ob0 = oe_bad; ar0 = ale_rises;
    cur_wdata = wd;
    cur_rd = 16'($urandom);
    rio = io; rwr = wr; raddr = a; rwdata = wd; rbe = be; req = 1'b1;
    @(negedge clk); @(negedge clk);
    // change the request inputs while the cycle runs (R10)
    rio = ~io; rwr = ~wr; raddr = ~a; rwdata = ~wd; rbe = ~be;
    seen = 0;
    for (n = 0; n < 4000 && !seen; n++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    req = 1'b0;
    chk(seen, "R6 done seen", 32'(seen), 1);
    @(negedge clk);
    chk(sa_fall == exp_sa(a, be), "R2 latched address", 32'(sa_fall), 32'(exp_sa(a, be)));
    chk(la_fall == a[23:17], "R2 unlatched address", 32'(la_fall), 32'(a[23:17]));
    chk(ale_len == 2*H, "R2 latch enable width", 32'(ale_len), 32'(2*H));
    chk(sa_rise == sa_fall && la_rise == la_fall, "R3 address stable in latch phase",
        32'(sa_rise), 32'(sa_fall));
    chk(low_mask == exp_mask(io, wr), "R4 strobe select", 32'(low_mask), 32'(exp_mask(io, wr)));
    chk(multi_cnt == m0, "R4 single strobe", 32'(multi_cnt - m0), 0);
    chk(low_len == CMD*2*H, "R5 strobe width", 32'(low_len), 32'(CMD*2*H));
    chk(fall_with_strobe && overlap_cnt == ov0, "R5 strobe follows latch",
        32'(fall_with_strobe), 1);
    chk(done_cnt == d0 + 1 && done_ok_cnt == dk0 + 1, "R6 done pulse placement",
        32'(done_ok_cnt - dk0), 1);
    if (!wr) chk(rdata_rec == cur_rd, "R7 read data", 32'(rdata_rec), 32'(cur_rd));
    chk(oe_bad == ob0, "R8 data drive window", 32'(oe_bad - ob0), 0);
    chk(hbe_fall == exp_hbe(be) && sa_fall[0] == (be == 2'b10), "R9 byte lane map",
        32'({hbe_fall, sa_fall[0]}), 32'({exp_hbe(be), (be == 2'b10)}));
    chk(ale_rises == ar0 + 1, "R10 one cycle per request", 32'(ale_rises - ar0), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks + 1, errs + 1);
    $finish;
  end

  initial begin
    checks = 0; errs = 0; mon_en = 0;
    cur_wdata = 0; cur_rd = 0;
    req = 0; rio = 0; rwr = 0; raddr = 0; rwdata = 0; rbe = 0;
    rst_n = 1'b0;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(negedge clk);
    chk(iord_n && iowr_n && mrd_n && mwr_n && hbe_n && !ale && !oe && !done,
        "R11 state in reset", 32'({iord_n, iowr_n, mrd_n, mwr_n, hbe_n, ale, oe, done}), 32'hF8);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(iord_n && iowr_n && mrd_n && mwr_n && hbe_n && !ale && !oe && !done,
        "R11 state after reset", 32'({iord_n, iowr_n, mrd_n, mwr_n, hbe_n, ale, oe, done}), 32'hF8);
    mon_en = 1;
    repeat (8*H) @(negedge clk);
    chk(bper == 2*H, "R1 bus clock period", 32'(bper), 32'(2*H));

    // directed: every kind, every byte pattern, address extremes
    do_op(1, 1, 24'h000300, 16'hA55A, 2'b11);
    do_op(1, 0, 24'h000301, 16'h0000, 2'b11);
    do_op(0, 1, 24'hFFFFFF, 16'h1234, 2'b10);
    do_op(0, 0, 24'h000000, 16'h0000, 2'b01);
    do_op(0, 1, 24'hABCDEF, 16'hFFFF, 2'b00);
    do_op(1, 0, 24'hFE0001, 16'h0000, 2'b10);
    do_op(0, 0, 24'h01FFFF, 16'h0000, 2'b11);
    do_op(1, 1, 24'h800000, 16'h8001, 2'b01);

    // random
    for (int i = 0; i < 40; i++)
      do_op(1'($urandom), 1'($urandom), 24'($urandom), 16'($urandom), 2'($urandom));

    chk(bper == 2*H, "R1 bus clock period after traffic", 32'(bper), 32'(2*H));
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule